// File: doc/BRIEF.md
# Breakpoint Region Lookup Unit

This unit keeps a short table of breakpoints, each holding an x coordinate and a y coordinate packed into one word. Given a query value, it finds the region the query falls into (the highest-indexed breakpoint whose x does not exceed the query) and reports that region's index together with the sum of the breakpoint's x and y fields. A later interpolation stage would consume the region index and the sum. That arithmetic is not part of this unit.

The table contents are fixed. Every entry is computed from a base and a step per field, and all entries are reloaded for as long as reset is held high. A lookup is requested with a one-cycle `start` pulse. The `seqMode` input, sampled with that pulse, picks one of two search methods. The first is a wide comparator that tests all entries at once and finishes one cycle later. The second is a scan that tests one entry per clock, starting at the top entry. The scan keeps the compare path short when the table is deep. Both methods give the same result. They differ only in latency.

Top module: `bpRegionLookup`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `noMatch`, `regionIdx` and `sumOut` are all 0.
- R2: Entry i holds x = X_BASE + i*X_STEP and y = Y_BASE + i*Y_STEP, each truncated to FW bits and packed as {y, x} with x in the low FW bits. The entries are loaded while reset is high and do not change afterwards.
- R3: The selected region is the highest index i for which the query (unsigned) is greater than or equal to x of entry i. Priority runs from entry DEPTH-1 down to entry 0.
- R4: On a match, `sumOut` equals x + y of the selected entry, computed at FW+1 bits so the sum never wraps.
- R5: When no entry satisfies the comparison, `noMatch` is 1, and `sumOut` and `regionIdx` are 0.
- R6: With `seqMode` = 0 at start, `done` is high for exactly one cycle, starting one clock after the start edge.
- R7: With `seqMode` = 1 at start, one entry is examined per clock, from DEPTH-1 downwards. `done` rises DEPTH-i clocks after the start edge for a match at index i, and DEPTH clocks after it when nothing matches.
- R8: `busy` is high from the cycle after the start edge until the cycle that `done` is high, and is low during that cycle. A `start` pulse while `busy` is high is ignored.
- R9: `regionIdx`, `sumOut` and `noMatch` change only together with a `done` pulse, and hold their values until the next one.
- R10: `queryIn` and `seqMode` are sampled only on the start edge. Later changes have no effect on the lookup in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; loads the table |
| start | input | 1 | One-cycle request to begin a lookup |
| seqMode | input | 1 | 0 = parallel compare, 1 = one-entry-per-cycle scan |
| queryIn | input | FW | Value to locate among the breakpoints |
| busy | output | 1 | Lookup in progress |
| done | output | 1 | One-cycle pulse when the result is updated |
| regionIdx | output | IW | Index of the selected entry |
| sumOut | output | FW+1 | x + y of the selected entry |
| noMatch | output | 1 | No entry satisfied the comparison |

## Verification
The bench builds the unit with four entries of 4-bit fields, x = 2, 5, 8, 11 and y = 1, 5, 9, 13. Because the first breakpoint lies above zero, the no-match case is reachable, and the largest sum (24) needs the extra output bit. Every one of the sixteen query values runs in both search modes. This covers each region, the exact boundary at every x, and every scan latency from one clock to DEPTH clocks. Extra runs change the query and mode after the start edge, and pulse `start` while the unit is busy.

// File: rtl/bp_lookup_pkg.sv
package bp_lookup_pkg;

  // Strobes from the controller to the datapath
  typedef struct packed {
    logic loadQuery;  // capture queryIn at the start edge
    logic takePar;    // store the parallel comparator result
    logic takeSeq;    // store the entry under the scan pointer
    logic takeMiss;   // store the no-match result
  } lkStrobe_t;

  typedef enum logic [1:0] {
    LK_IDLE = 2'd0,
    LK_PAR  = 2'd1,
    LK_SCAN = 2'd2
  } lkState_t;

  function automatic int fieldValue(input int base, input int step, input int idx);
    return base + step * idx;
  endfunction

endpackage

// File: rtl/bpTable.sv
module bpTable #(
  parameter int DEPTH  = 3,
  parameter int FW     = 3,
  parameter int X_BASE = 0,
  parameter int X_STEP = 1,
  parameter int Y_BASE = 0,
  parameter int Y_STEP = 1,
  localparam int EW    = 2 * FW
) (
  input  logic                clk,
  input  logic                rst,
  output logic [DEPTH*EW-1:0] tableFlat
);
  import bp_lookup_pkg::*;

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    localparam int XV = fieldValue(X_BASE, X_STEP, g);
    localparam int YV = fieldValue(Y_BASE, Y_STEP, g);
    localparam logic [FW-1:0] XF = XV[FW-1:0];
    localparam logic [FW-1:0] YF = YV[FW-1:0];

    // y in the upper field, x in the lower field
    always_ff @(posedge clk) begin
      if (rst) tableFlat[g*EW +: EW] <= {YF, XF};
    end
  end

  // R2: contents are frozen once reset is released
  assert_table_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(tableFlat));

endmodule

// File: rtl/bpDatapath.sv
module bpDatapath #(
  parameter int DEPTH = 3,
  parameter int FW    = 3,
  parameter int IW    = 2,
  localparam int EW   = 2 * FW
) (
  input  logic                       clk,
  input  logic                       rst,
  input  bp_lookup_pkg::lkStrobe_t   strobe,
  input  logic [IW-1:0]              scanIdx,
  input  logic [FW-1:0]              queryIn,
  input  logic [DEPTH*EW-1:0]        tableFlat,
  output logic                       seqHit,
  output logic [IW-1:0]              regionIdx,
  output logic [FW:0]                sumOut,
  output logic                       noMatch
);

  logic [FW-1:0] queryReg;
  logic          parHit;
  logic [IW-1:0] parIdx;
  logic [FW:0]   parSum;
  logic [EW-1:0] selEntry;
  logic [FW:0]   selSum;

  always_ff @(posedge clk) begin
    if (rst)                   queryReg <= '0;
    else if (strobe.loadQuery) queryReg <= queryIn;
  end

  // Wide comparator: the last satisfying index wins, giving top-down priority
  always_comb begin
    parHit = 1'b0;
    parIdx = '0;
    parSum = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (queryReg >= tableFlat[i*EW +: FW]) begin
        parHit = 1'b1;
        parIdx = IW'(i);
        parSum = {1'b0, tableFlat[i*EW +: FW]} + {1'b0, tableFlat[i*EW + FW +: FW]};
      end
    end
  end

  // Single-entry compare for the scan
  always_comb begin
    selEntry = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (scanIdx == IW'(i)) selEntry = tableFlat[i*EW +: EW];
    end
  end

  assign seqHit = (queryReg >= selEntry[FW-1:0]);
  assign selSum = {1'b0, selEntry[FW-1:0]} + {1'b0, selEntry[EW-1:FW]};

  always_ff @(posedge clk) begin
    if (rst) begin
      regionIdx <= '0;
      sumOut    <= '0;
      noMatch   <= 1'b0;
    end else if (strobe.takePar) begin
      regionIdx <= parHit ? parIdx : '0;
      sumOut    <= parHit ? parSum : '0;
      noMatch   <= !parHit;
    end else if (strobe.takeSeq) begin
      regionIdx <= scanIdx;
      sumOut    <= selSum;
      noMatch   <= 1'b0;
    end else if (strobe.takeMiss) begin
      regionIdx <= '0;
      sumOut    <= '0;
      noMatch   <= 1'b1;
    end
  end

  // R5: a miss always reports an all-zero region and sum
  assert_nomatch_zero_R5: assert property (@(posedge clk) disable iff (rst)
    noMatch |-> (sumOut == '0) && (regionIdx == '0));

  // R3: a stored scan hit never points past the last entry
  assert_region_range_R3: assert property (@(posedge clk) disable iff (rst)
    !noMatch |-> (int'(regionIdx) < DEPTH));

endmodule

// File: rtl/bpControl.sv
module bpControl #(
  parameter int DEPTH = 3,
  parameter int IW    = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     seqMode,
  input  logic                     seqHit,
  output bp_lookup_pkg::lkStrobe_t strobe,
  output logic [IW-1:0]            scanIdx,
  output logic                     busy,
  output logic                     done
);
  import bp_lookup_pkg::*;

  localparam logic [IW-1:0] TOP_IDX = IW'(DEPTH - 1);

  lkState_t state, stateNext;
  logic     doneNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    doneNext  = 1'b0;
    case (state)
      LK_IDLE: begin
        if (start) begin
          strobe.loadQuery = 1'b1;
          stateNext = seqMode ? LK_SCAN : LK_PAR;
        end
      end
      LK_PAR: begin
        strobe.takePar = 1'b1;
        doneNext  = 1'b1;
        stateNext = LK_IDLE;
      end
      LK_SCAN: begin
        if (seqHit) begin
          strobe.takeSeq = 1'b1;
          doneNext  = 1'b1;
          stateNext = LK_IDLE;
        end else if (scanIdx == '0) begin
          strobe.takeMiss = 1'b1;
          doneNext  = 1'b1;
          stateNext = LK_IDLE;
        end
      end
      default: stateNext = LK_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LK_IDLE;
      scanIdx <= '0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= doneNext;
      if (strobe.loadQuery)                           scanIdx <= TOP_IDX;
      else if (state == LK_SCAN && stateNext == LK_SCAN) scanIdx <= scanIdx - 1'b1;
    end
  end

  assign busy = (state != LK_IDLE);

  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8: the unit is idle when it reports completion
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7: the scan pointer steps down by one each cycle it stays in the scan
  assert_scan_step_R7: assert property (@(posedge clk) disable iff (rst)
    (state == LK_SCAN) && ($past(state) == LK_SCAN) |-> scanIdx == $past(scanIdx) - 1'b1);

endmodule

// File: rtl/bpRegionLookup.sv
module bpRegionLookup #(
  parameter int DEPTH  = 3,
  parameter int FW     = 3,
  parameter int X_BASE = 0,
  parameter int X_STEP = 1,
  parameter int Y_BASE = 0,
  parameter int Y_STEP = 1,
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int EW    = 2 * FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          seqMode,
  input  logic [FW-1:0] queryIn,
  output logic          busy,
  output logic          done,
  output logic [IW-1:0] regionIdx,
  output logic [FW:0]   sumOut,
  output logic          noMatch
);
  import bp_lookup_pkg::*;

  logic [DEPTH*EW-1:0] tableFlat;
  lkStrobe_t           strobe;
  logic [IW-1:0]       scanIdx;
  logic                seqHit;

  bpTable #(
    .DEPTH(DEPTH), .FW(FW),
    .X_BASE(X_BASE), .X_STEP(X_STEP), .Y_BASE(Y_BASE), .Y_STEP(Y_STEP)
  ) u_table (
    .clk(clk), .rst(rst), .tableFlat(tableFlat)
  );

  bpControl #(.DEPTH(DEPTH), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .seqMode(seqMode), .seqHit(seqHit),
    .strobe(strobe), .scanIdx(scanIdx), .busy(busy), .done(done)
  );

  bpDatapath #(.DEPTH(DEPTH), .FW(FW), .IW(IW)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .scanIdx(scanIdx), .queryIn(queryIn),
    .tableFlat(tableFlat), .seqHit(seqHit), .regionIdx(regionIdx),
    .sumOut(sumOut), .noMatch(noMatch)
  );

  // R9: results move only with a completion pulse
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(sumOut) && $stable(regionIdx) && $stable(noMatch));

endmodule

// File: tb/bpRegionLookup_tb.sv
`timescale 1ns/1ps
module bpRegionLookup_tb;
  localparam int DEPTH = 4, FW = 4, IW = 2;
  localparam int XB = 2, XS = 3, YB = 1, YS = 4;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, seqMode = 1'b0;
  logic [FW-1:0] queryIn = '0;
  logic busy, done, noMatch;
  logic [IW-1:0] regionIdx;
  logic [FW:0] sumOut;
  int nChecks = 0, nFail = 0;

  always #2.5 clk = ~clk;

  bpRegionLookup #(.DEPTH(DEPTH), .FW(FW), .X_BASE(XB), .X_STEP(XS),
                   .Y_BASE(YB), .Y_STEP(YS)) u_dut (
    .clk(clk), .rst(rst), .start(start), .seqMode(seqMode), .queryIn(queryIn),
    .busy(busy), .done(done), .regionIdx(regionIdx), .sumOut(sumOut), .noMatch(noMatch));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model from R2/R3: highest i with q >= x_i, or -1
  function automatic int modelIdx(input int q);
    int r = -1;
    for (int i = 0; i < DEPTH; i++) if (q >= ((XB + XS*i) % 16)) r = i;
    return r;
  endfunction

  function automatic int modelSum(input int i);
    return ((XB + XS*i) % 16) + ((YB + YS*i) % 16);
  endfunction

  task automatic lookup(input int q, input bit mode, input bit poke);
    int lat, ei, es, el, holdSum;
    @(negedge clk);
    queryIn = q[FW-1:0]; seqMode = mode; start = 1'b1;
    @(negedge clk);
    start = 1'b0; queryIn = ~q[FW-1:0]; seqMode = !mode;   // R10
    check(busy == 1'b1, "R8 busy after start", int'(busy), 1);
    if (poke) begin
      queryIn = 4'd14; start = 1'b1;                       // R8 ignored restart
      @(negedge clk); start = 1'b0;
    end
    lat = poke ? 1 : 0;
    while (!done && lat < 50) begin
      @(posedge clk); lat++;
      @(negedge clk);
    end
    ei = modelIdx(q);
    es = (ei < 0) ? 0 : modelSum(ei);
    el = !mode ? 1 : ((ei < 0) ? DEPTH : DEPTH - ei);
    check(lat == el, mode ? "R7 scan latency" : "R6 parallel latency", lat, el);
    check(busy == 1'b0, "R8 busy low at done", int'(busy), 0);
    check(int'(noMatch) == int'(ei < 0), "R5 noMatch flag", int'(noMatch), int'(ei < 0));
    check(int'(regionIdx) == ((ei < 0) ? 0 : ei), "R3 region index", int'(regionIdx), (ei < 0) ? 0 : ei);
    check(int'(sumOut) == es, "R4 sum of fields", int'(sumOut), es);
    holdSum = int'(sumOut);
    queryIn = 4'd0;
    @(negedge clk);
    check(done == 1'b0, "R6 done single pulse", int'(done), 0);
    check(int'(sumOut) == holdSum, "R9 result held", int'(sumOut), holdSum);
  endtask

  initial begin
    #500000;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(done == 0 && busy == 0 && sumOut == 0 && noMatch == 0 && regionIdx == 0,
          "R1 outputs during reset", int'(sumOut), 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && busy == 0 && sumOut == 0 && noMatch == 0,
          "R1 outputs after reset", int'({busy, done, noMatch}), 0);
    // R2 R3 R4 R5 R6 R7 R10: full sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int q = 0; q < 16; q++) lookup(q, m[0], 1'b0);
    // R8: restart attempt while scanning (q=3 lands on entry 0)
    lookup(3, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    check(done == 0 && busy == 0, "R8 no deferred lookup", int'({busy, done}), 0);
    check(int'(sumOut) == modelSum(0), "R8 result kept after ignored start", int'(sumOut), modelSum(0));
    // R2: table reloads under a second reset and lookups still agree
    rst = 1'b1; repeat (2) @(negedge clk); rst = 1'b0;
    lookup(15, 1'b0, 1'b0);
    lookup(1, 1'b1, 1'b0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule